// File: doc/BRIEF.md
# Iterative 32x32 Multiplier with Multiply-Accumulate

This unit multiplies two 32-bit integers for an integer pipeline. It owns one 16x16 multiplier array and walks it over four cycles. Each cycle it forms one partial product, moves it to its bit offset and adds it into a 64-bit running sum. A signed multiply runs on operand magnitudes. The sum is negated at the end when exactly one operand was negative. A build parameter puts a register between the array and the adder, which adds one cycle and gives five cycles in all.

In the four-cycle build the same array also serves a multiply-accumulate operation. The low halves of the two operands are multiplied in one cycle. The 32-bit product is widened to 40 bits, by sign extension for signed or zero extension for unsigned, and added into a 40-bit accumulator. The caller can clear the accumulator at any time.

Top module: `imul_unit`

## Requirements
- R1: With `mac_i`=0 and `signed_i`=0, `result_o` gives the full unsigned 64-bit product of `a_i` and `b_i`.
- R2: With `mac_i`=0 and `signed_i`=1, `result_o` gives the two's-complement 64-bit product. This includes operands equal to -2^31 and a zero operand paired with a negative one.
- R3: A multiply start taken at clock edge E sets `busy_o` from the next cycle. `done_o` rises after edge E+4 when `PIPE_STAGE`=0, and after edge E+5 when `PIPE_STAGE`=1. `busy_o` falls in the same cycle that `done_o` rises.
- R4: Each multiply raises `done_o` for exactly one cycle, and `busy_o` is never high at the same time. `result_o` changes only in a cycle where `done_o` is high, and holds its value until the next multiply completes.
- R5: A start while `busy_o` is high is ignored. It does not change the result being built and produces no extra `done_o`.
- R6: With `mac_i`=1 and `PIPE_STAGE`=0, a start taken at edge E multiplies `a_i[15:0]` by `b_i[15:0]` and adds the product into the accumulator at edge E. `done_o` is high in the next cycle. `busy_o` stays low, `result_o` is unchanged and `a_i[31:16]`/`b_i[31:16]` are ignored.
- R7: A signed multiply-accumulate treats both 16-bit halves as two's complement and sign-extends the 32-bit product to 40 bits. An unsigned one zero-extends the product.
- R8: `acc_o` is 40 bits wide and wraps modulo 2^40.
- R9: `acc_clr_i` high at an edge zeroes the accumulator. If a multiply-accumulate is accepted at the same edge, the accumulator takes that product alone.
- R10: When `PIPE_STAGE`=1, a start with `mac_i`=1 is ignored. `done_o` stays low, `busy_o` stays low and `acc_o` is unchanged.
- R11: After reset `busy_o`, `done_o`, `result_o` and `acc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request an operation; taken only while not busy |
| mac_i | input | 1 | 0 = 32x32 multiply, 1 = 16x16 multiply-accumulate |
| signed_i | input | 1 | 1 = operands are two's complement |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_clr_i | input | 1 | Zero the accumulator |
| busy_o | output | 1 | A multiply is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Last multiply product |
| acc_o | output | 40 | Accumulator value |

## Verification
Two functions can fall in the same cycle: an accumulator clear and an accepted multiply-accumulate. The bench first builds a non-zero accumulator. It then raises `acc_clr_i` and a multiply-accumulate start in one cycle, and expects the accumulator to hold only the new product, not zero and not the old sum plus the product. A second collision is a start arriving while a multiply is under way. The bench holds such a start for two cycles during a multiply and expects the first operands' product, one `done_o`, and the normal completion cycle.

// File: rtl/imul_pkg.sv
`timescale 1ns/1ps
// Shared widths and helpers for the iterative multiplier.
// Assumes the operand width is even so it splits into two halves.
package imul_pkg;
    parameter int unsigned OPW = 32;          // operand width
    parameter int unsigned HW  = OPW / 2;     // half-operand width
    parameter int unsigned PW  = 2 * OPW;     // full product width
    parameter int unsigned AW  = 40;          // accumulator width
    parameter int unsigned HPW = 2 * HW;      // partial product width

    // Partial product index: bit 1 picks the high half of A, bit 0 the high half of B
    typedef logic [1:0] pp_idx_t;
    localparam pp_idx_t LAST_PP = 2'd3;

    // Places a partial product at its offset in the full-width sum
    function automatic logic [PW-1:0] place_pp(input logic [HPW-1:0] pp, input pp_idx_t idx);
        logic [PW-1:0] wide;
        wide = {{(PW-HPW){1'b0}}, pp};
        case (idx)
            2'd0:    place_pp = wide;
            2'd3:    place_pp = wide << (2 * HW);
            default: place_pp = wide << HW;
        endcase
    endfunction
endpackage

// File: rtl/imul_array16.sv
`timescale 1ns/1ps
// Half-width multiplier array, purely combinational.
// sgn_i=1 treats both inputs as two's complement; the low HPW bits are
// returned, which are exact for both signed and unsigned inputs.
module imul_array16
    import imul_pkg::*;
(
    input  logic [HW-1:0]  x_i,
    input  logic [HW-1:0]  y_i,
    input  logic           sgn_i,
    output logic [HPW-1:0] p_o
);
    logic signed [HW:0]    xs;
    logic signed [HW:0]    ys;
    logic signed [HPW+1:0] full;

    // Extends each input by one bit then multiplies as signed numbers
    always_comb begin
        xs   = {sgn_i & x_i[HW-1], x_i};
        ys   = {sgn_i & y_i[HW-1], y_i};
        full = xs * ys;
        p_o  = full[HPW-1:0];
    end
endmodule

// File: rtl/imul_seq.sv
`timescale 1ns/1ps
// Multiply sequencer: takes operand magnitudes, issues four half-width
// partial products to the shared array, sums them and fixes the sign.
// PIPE_STAGE=1 registers each partial product before the adder.
// Assumes go_i is raised only while busy_o is low.
module imul_seq
    import imul_pkg::*;
#(
    parameter int unsigned PIPE_STAGE = 0
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic           sgn_i,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic [HPW-1:0] pp_i,
    output logic [HW-1:0]  x_o,
    output logic [HW-1:0]  y_o,
    output logic           busy_o,
    output logic           fin_o,
    output logic [PW-1:0]  prod_o
);
    logic [OPW-1:0] mag_a, mag_b;
    logic           neg_q;
    logic           issuing;
    pp_idx_t        iss_idx;
    logic [PW-1:0]  sum_q;
    logic [PW-1:0]  total;
    logic           fin_q;
    logic [PW-1:0]  prod_q;

    logic           add_vld;
    pp_idx_t        add_idx;
    logic [HPW-1:0] add_pp;
    logic           stage_busy;

    // Captures operand magnitudes and steps through the four partial products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a   <= '0;
            mag_b   <= '0;
            neg_q   <= 1'b0;
            issuing <= 1'b0;
            iss_idx <= '0;
        end else if (go_i) begin
            mag_a   <= (sgn_i && a_i[OPW-1]) ? (~a_i + 1'b1) : a_i;
            mag_b   <= (sgn_i && b_i[OPW-1]) ? (~b_i + 1'b1) : b_i;
            neg_q   <= sgn_i & (a_i[OPW-1] ^ b_i[OPW-1]);
            issuing <= 1'b1;
            iss_idx <= '0;
        end else if (issuing) begin
            iss_idx <= iss_idx + 1'b1;
            if (iss_idx == LAST_PP) begin
                issuing <= 1'b0;
            end
        end
    end

    // Selects the operand halves for the current partial product
    always_comb begin
        x_o = iss_idx[1] ? mag_a[OPW-1:HW] : mag_a[HW-1:0];
        y_o = iss_idx[0] ? mag_b[OPW-1:HW] : mag_b[HW-1:0];
    end

    generate
        if (PIPE_STAGE != 0) begin : g_pipe
            logic           st_vld;
            pp_idx_t        st_idx;
            logic [HPW-1:0] st_pp;

            // Holds one partial product between the array and the adder
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_vld <= 1'b0;
                    st_idx <= '0;
                    st_pp  <= '0;
                end else begin
                    st_vld <= issuing;
                    st_idx <= iss_idx;
                    st_pp  <= pp_i;
                end
            end

            assign add_vld    = st_vld;
            assign add_idx    = st_idx;
            assign add_pp     = st_pp;
            assign stage_busy = st_vld;
        end else begin : g_direct
            assign add_vld    = issuing;
            assign add_idx    = iss_idx;
            assign add_pp     = pp_i;
            assign stage_busy = 1'b0;
        end
    endgenerate

    // Forms the running sum including the arriving partial product
    always_comb begin
        total = sum_q + place_pp(add_pp, add_idx);
    end

    // Accumulates partial products and publishes the signed-corrected result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            fin_q  <= 1'b0;
            prod_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (add_vld) begin
                if (add_idx == LAST_PP) begin
                    sum_q  <= '0;
                    fin_q  <= 1'b1;
                    prod_q <= neg_q ? (~total + 1'b1) : total;
                end else begin
                    sum_q  <= total;
                end
            end
        end
    end

    assign busy_o = issuing | stage_busy;
    assign fin_o  = fin_q;
    assign prod_o = prod_q;
endmodule

// File: rtl/imul_mac.sv
`timescale 1ns/1ps
// Multiply-accumulate register: widens a half-width product and adds it
// into the accumulator. A clear at the same edge as an add leaves only
// the new product. Assumes p_i is the array output for the same cycle.
module imul_mac
    import imul_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           go_i,
    input  logic           sgn_i,
    input  logic [HPW-1:0] p_i,
    output logic [AW-1:0]  acc_o,
    output logic           done_o
);
    logic [AW-1:0] acc_q;
    logic [AW-1:0] widened;
    logic          done_q;

    // Sign- or zero-extends the product to accumulator width
    always_comb begin
        widened = {{(AW-HPW){sgn_i & p_i[HPW-1]}}, p_i};
    end

    // Updates the accumulator with clear taking effect before the add
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= go_i;
            if (go_i) begin
                acc_q <= (clr_i ? '0 : acc_q) + widened;
            end else if (clr_i) begin
                acc_q <= '0;
            end
        end
    end

    assign acc_o  = acc_q;
    assign done_o = done_q;
endmodule

// File: rtl/imul_unit.sv
`timescale 1ns/1ps
// Iterative multiplier top: one half-width array shared between the
// four-step 32x32 multiply and the single-cycle multiply-accumulate.
// Multiply-accumulate exists only when PIPE_STAGE=0; otherwise such
// requests are dropped. Assumes callers hold operands only in the start cycle.
module imul_unit
    import imul_pkg::*;
#(
    parameter int unsigned PIPE_STAGE = 0
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           mac_i,
    input  logic           signed_i,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           acc_clr_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [PW-1:0]  result_o,
    output logic [AW-1:0]  acc_o
);
    localparam bit MAC_OK = (PIPE_STAGE == 0);

    logic           seq_busy;
    logic           seq_fin;
    logic           mul_go;
    logic           mac_go;
    logic           mac_done;
    logic [HW-1:0]  seq_x, seq_y;
    logic [HW-1:0]  arr_x, arr_y;
    logic           arr_sgn;
    logic [HPW-1:0] arr_p;

    // Decodes accepted requests; any start while busy is dropped
    always_comb begin
        mul_go = start_i & ~seq_busy & ~mac_i;
        mac_go = start_i & ~seq_busy & mac_i & MAC_OK;
    end

    // Routes the array to the sequencer while busy, else to the MAC operands
    always_comb begin
        arr_x   = seq_busy ? seq_x : a_i[HW-1:0];
        arr_y   = seq_busy ? seq_y : b_i[HW-1:0];
        arr_sgn = ~seq_busy & signed_i;
    end

    imul_array16 u_array (
        .x_i   (arr_x),
        .y_i   (arr_y),
        .sgn_i (arr_sgn),
        .p_o   (arr_p)
    );

    imul_seq #(.PIPE_STAGE(PIPE_STAGE)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mul_go),
        .sgn_i  (signed_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .pp_i   (arr_p),
        .x_o    (seq_x),
        .y_o    (seq_y),
        .busy_o (seq_busy),
        .fin_o  (seq_fin),
        .prod_o (result_o)
    );

    imul_mac u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (acc_clr_i),
        .go_i   (mac_go),
        .sgn_i  (signed_i),
        .p_i    (arr_p),
        .acc_o  (acc_o),
        .done_o (mac_done)
    );

    assign busy_o = seq_busy;
    assign done_o = seq_fin | mac_done;
endmodule

// File: rtl/imul_unit_chk.sv
`timescale 1ns/1ps
// Protocol checker for imul_unit, attached by bind. Observes ports only.
module imul_unit_chk
    import imul_pkg::*;
#(
    parameter int unsigned PIPE_STAGE = 0
)(
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           mac_i,
    input logic           signed_i,
    input logic [OPW-1:0] a_i,
    input logic [OPW-1:0] b_i,
    input logic           acc_clr_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [PW-1:0]  result_o,
    input logic [AW-1:0]  acc_o
);
    localparam bit          MAC_OK = (PIPE_STAGE == 0);
    localparam int unsigned LAT    = 4 + PIPE_STAGE;

    logic [3:0] busy_run;
    logic       mac_take;

    assign mac_take = start_i && !busy_o && mac_i && MAC_OK;

    // Counts consecutive busy cycles to bound the multiply window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= (busy_run == 4'hF) ? busy_run : busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_done_at_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_mul_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !mac_i) |=> busy_o);

    assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= LAT[3:0]);

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    assert_mac_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mac_i) |=> !busy_o);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr_i && !mac_take) |=> (acc_o == '0));

    assert_mac_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!MAC_OK && !acc_clr_i) |=> $stable(acc_o));
endmodule

bind imul_unit imul_unit_chk #(.PIPE_STAGE(PIPE_STAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mac_i     (mac_i),
    .signed_i  (signed_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .acc_clr_i (acc_clr_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .acc_o     (acc_o)
);

// File: tb/imul_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module imul_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start0 = 1'b0, start5 = 1'b0;
    logic        mac = 1'b0, sgn = 1'b0, clr = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        busy0, done0, busy5, done5;
    logic [63:0] res0, res5;
    logic [39:0] acc0, acc5;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [39:0] model_acc = '0;

    always #10 clk = ~clk;

    imul_unit #(.PIPE_STAGE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start0), .mac_i(mac), .signed_i(sgn),
        .a_i(a), .b_i(b), .acc_clr_i(clr), .busy_o(busy0), .done_o(done0),
        .result_o(res0), .acc_o(acc0));

    imul_unit #(.PIPE_STAGE(1)) dut5_i (
        .clk(clk), .rst_n(rst_n), .start_i(start5), .mac_i(mac), .signed_i(sgn),
        .a_i(a), .b_i(b), .acc_clr_i(clr), .busy_o(busy5), .done_o(done5),
        .result_o(res5), .acc_o(acc5));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] gold_mul(input logic [31:0] x, input logic [31:0] y, input bit s);
        longint sx, sy;
        if (s) begin
            sx = longint'($signed(x));
            sy = longint'($signed(y));
            return 64'(sx * sy);
        end
        return {32'b0, x} * {32'b0, y};
    endfunction

    function automatic logic [39:0] gold_mac(input logic [15:0] x, input logic [15:0] y, input bit s);
        int p;
        if (s) begin
            p = int'($signed(x)) * int'($signed(y));
            return {{8{p[31]}}, p};
        end
        return {8'b0, {16'b0, x} * {16'b0, y}};
    endfunction

    // Runs one multiply on the chosen unit and checks latency and product
    task automatic t_mul(input logic [31:0] x, input logic [31:0] y, input bit s, input bit on5);
        int    cnt;
        int    lat;
        string tag;
        tag = s ? "R2" : "R1";
        lat = on5 ? 5 : 4;
        @(negedge clk);
        a = x; b = y; sgn = s; mac = 1'b0;
        if (on5) start5 = 1'b1; else start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0; start5 = 1'b0;
        chk("R3 busy after start", {63'b0, on5 ? busy5 : busy0}, 64'd1);
        cnt = 0;
        while (!(on5 ? done5 : done0) && cnt < 12) begin
            @(negedge clk);
            cnt++;
        end
        chk("R3 latency", 64'(cnt), 64'(lat));
        chk("R3 busy low at done", {63'b0, on5 ? busy5 : busy0}, 64'd0);
        chk(tag, on5 ? res5 : res0, gold_mul(x, y, s));
    endtask

    // Issues one multiply-accumulate on the four-cycle unit
    task automatic t_mac(input logic [31:0] x, input logic [31:0] y, input bit s, input bit c, input string tag);
        logic [63:0] res_before;
        res_before = res0;
        @(negedge clk);
        a = x; b = y; sgn = s; mac = 1'b1; clr = c; start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0; clr = 1'b0; mac = 1'b0;
        model_acc = (c ? 40'd0 : model_acc) + gold_mac(x[15:0], y[15:0], s);
        chk({tag, " acc"}, {24'b0, acc0}, {24'b0, model_acc});
        chk("R6 done next cycle", {63'b0, done0}, 64'd1);
        chk("R6 busy stays low", {63'b0, busy0}, 64'd0);
        chk("R6 result unchanged", res0, res_before);
    endtask

    task automatic t_reset;
        chk("R11 busy", {63'b0, busy0}, 64'd0);
        chk("R11 done", {63'b0, done0}, 64'd0);
        chk("R11 result", res0, 64'd0);
        chk("R11 acc", {24'b0, acc0}, 64'd0);
    endtask

    task automatic t_unsigned;
        t_mul(32'd7, 32'd9, 1'b0, 1'b0);
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
        t_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b0);
        t_mul(32'h0001_0000, 32'h0000_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_signed;
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        t_mul(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
        t_mul(32'h8000_0000, 32'd1, 1'b1, 1'b0);
        t_mul(32'd5, -32'sd7, 1'b1, 1'b0);
        t_mul(32'd0, -32'sd5, 1'b1, 1'b0);
    endtask

    // Start held during a multiply must not disturb it (R5) and result holds (R4)
    task automatic t_busy_start;
        int          cnt;
        int          n_done;
        logic [63:0] held;
        @(negedge clk);
        a = 32'h0000_1111; b = 32'h0000_2222; sgn = 1'b0; mac = 1'b0; start0 = 1'b1;
        @(negedge clk);
        a = 32'hDEAD_BEEF; b = 32'hCAFE_F00D;
        cnt = 0; n_done = 0;
        @(negedge clk); cnt++;
        start0 = 1'b0;
        while (!done0 && cnt < 12) begin
            @(negedge clk);
            cnt++;
        end
        chk("R5 latency unchanged", 64'(cnt), 64'd4);
        chk("R5 first operands kept", res0, gold_mul(32'h0000_1111, 32'h0000_2222, 1'b0));
        held = res0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done0) n_done++;
        end
        chk("R5 no extra done", 64'(n_done), 64'd0);
        chk("R4 result holds", res0, held);
    endtask

    task automatic t_mac_basic;
        t_mac(32'h0, 32'h0, 1'b0, 1'b1, "R9 clear");
        t_mac(32'hABCD_FFFF, 32'h1234_FFFF, 1'b0, 1'b0, "R6 unsigned high halves ignored");
        t_mac(32'h0000_8000, 32'h0000_8000, 1'b1, 1'b0, "R7 signed min");
        t_mac(32'h0000_FFFF, 32'h0000_0003, 1'b1, 1'b0, "R7 signed negative");
    endtask

    task automatic t_wrap;
        t_mac(32'h0000_FFFF, 32'h0000_0001, 1'b1, 1'b1, "R8 all ones");
        chk("R8 all ones value", {24'b0, acc0}, {24'b0, 40'hFF_FFFF_FFFF});
        t_mac(32'h1, 32'h1, 1'b0, 1'b0, "R8 wrap");
        chk("R8 wrapped to zero", {24'b0, acc0}, 64'd0);
    endtask

    // Clear colliding with an accepted multiply-accumulate, then a plain clear
    task automatic t_clear;
        t_mac(32'h100, 32'h100, 1'b0, 1'b0, "R9 build");
        t_mac(32'd3, 32'd4, 1'b0, 1'b1, "R9 clear with add");
        chk("R9 only new product", {24'b0, acc0}, 64'd12);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_acc = '0;
        chk("R9 plain clear", {24'b0, acc0}, 64'd0);
    endtask

    task automatic t_five;
        int n_done;
        t_mul(32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 1'b1);
        t_mul(32'h8765_4321, 32'h1357_9BDF, 1'b0, 1'b1);
        @(negedge clk);
        a = 32'd9; b = 32'd9; sgn = 1'b0; mac = 1'b1; start5 = 1'b1;
        @(negedge clk);
        start5 = 1'b0; mac = 1'b0;
        n_done = done5 ? 1 : 0;
        chk("R10 no busy", {63'b0, busy5}, 64'd0);
        @(negedge clk);
        if (done5) n_done++;
        chk("R10 no done", 64'(n_done), 64'd0);
        chk("R10 acc unchanged", {24'b0, acc5}, 64'd0);
    endtask

    bit reported = 1'b0;
    task automatic report;
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_busy_start();
        t_mac_basic();
        t_wrap();
        t_clear();
        t_five();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule